// File: doc/BRIEF.md
# Translation Lookaside Buffer with Fault Capture

This block is a small, fully associative address translation cache. It is placed beside a processor's load/store path. Each lookup presents a virtual address together with write and user-mode qualifiers. In the same cycle the block returns the physical address. A lookup that finds no entry, or that finds an entry whose permissions forbid the access, raises an access-error indication instead. On the clock edge at the end of that lookup, the faulting address and a cause code are captured into registers that software can read.

Software manages the buffer through a 64 KB register window in the memory map. A 32-bit base register places the window: bits 31..16 give its location and bit 0 enables it. Through the window, software can:
- stage a tag word and a data word, then commit them as an entry, either at an index it names or at the slot chosen by a round-robin pointer;
- invalidate every entry with one command;
- probe an address, which reports a hit and the matching index without performing an access.

Each entry covers a 4 KB, 64 KB or 1 MB page.

Top module: `tlb_xlat`

## Requirements
- R1: A lookup (lkValid=1) that matches a valid entry and breaks no permission drives lkHit=1 and accErr=0 in the same cycle. It drives lkPhys = the entry's physical page bits above the page size, joined to the virtual address bits below it.
- R2: The tag size code selects the page size: 0 is 4 KB (compare bits 31..12), 1 is 64 KB (compare bits 31..16), and 2 or 3 is 1 MB (compare bits 31..20). Bits below the page size are left out of the compare and pass straight through to lkPhys.
- R3: A lookup that matches no valid entry drives lkHit=0 and accErr=1 in the same cycle, and records cause code 1.
- R4: A lookup that hits is an error when it writes to an entry whose writable bit is 0 (cause 2), or when it is a user access to an entry whose user bit is 0 (cause 3). When both apply, cause 3 wins.
- R5: At the clock edge of an erroring lookup, the fault address register (window offset 0x14) takes lkAddr and the cause register (offset 0x18, bits 1..0) takes the cause. Both hold their values until the next error. Both reset to 0.
- R6: A command word (offset 0x08) with bit 1 set invalidates every entry in one edge. Its effect wins over a write-entry bit in the same word.
- R7: A command with bit 2 set compares the probe address (offset 0x0C) against the entries. It loads the probe result (offset 0x10) with bit 31 = hit and bits 2..0 = the lowest matching index, or with 0 on a miss. A probe never changes the fault registers.
- R8: The base register resets to 0. A write keeps bits 31..16 and bit 0; reads return 0 in bits 15..1.
- R9: While base bit 0 is 0, or while busAddr[31:16] differs from the base field, window reads return 0 and window writes change nothing.
- R10: A window access with busAddr[1:0] != 0 is ignored and sets status bit 0 (offset 0x1C). An aligned write to the status offset clears that bit.
- R11: A command with bit 0 set writes the staged tag (offset 0x00: vpn in bits 31..12, size in 1..0) and data (offset 0x04: ppn in 31..12, user bit 1, writable bit 0) as a valid entry. If command bit 3 is set, the entry goes to the index in bits 6..4. Otherwise it goes to the round-robin pointer, which then advances modulo 8. The pointer resets to 0.
- R12: When several valid entries match a lookup, the one with the lowest index supplies the translation and the permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWe | input | 1 | Base register write strobe |
| baseWdata | input | 32 | Base register write data |
| baseRdata | output | 32 | Base register read value |
| busValid | input | 1 | Register-window access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Register-window byte address |
| busWdata | input | 32 | Register-window write data |
| busRdata | output | 32 | Register-window read data (combinational) |
| lkValid | input | 1 | Translation lookup request |
| lkAddr | input | 32 | Virtual address to translate |
| lkWrite | input | 1 | Lookup is a write |
| lkUser | input | 1 | Lookup is made in user mode |
| lkHit | output | 1 | A valid entry matches lkAddr |
| lkPhys | output | 32 | Translated physical address |
| accErr | output | 1 | Access error for the current lookup |

## Verification
The assertions assume two things about the inputs:
- lkValid, lkAddr and the window signals are stable and known around each rising edge;
- a lookup, a window command and a base write may fall in the same cycle, and when they do, the lookup sees the entries as they were before that edge.

The bench drives every input at the falling edge and samples outputs shortly afterwards. It holds lkValid low while it reads the fault registers, so each captured address can be traced to exactly one lookup. Random entries draw their tags from four fixed prefixes, so that hits, multiple hits and every page size occur often.

// File: rtl/tlb_xlat_pkg.sv
package tlb_xlat_pkg;
  parameter int unsigned TlbEntries = 8;
  localparam int unsigned IdxW = $clog2(TlbEntries);
  localparam int unsigned PageW = 20;

  typedef enum logic [1:0] {
    CauseNone   = 2'd0,
    CauseMiss   = 2'd1,
    CauseWrProt = 2'd2,
    CausePriv   = 2'd3
  } cause_e;

  // strobes from the window control to the datapath
  typedef struct packed {
    logic            wrEntry;
    logic            useIdx;
    logic [IdxW-1:0] idx;
    logic            clrAll;
    logic            probe;
  } cmd_t;

  typedef struct packed {
    logic [PageW-1:0] vpn;
    logic [1:0]       size;
    logic [PageW-1:0] ppn;
    logic             wr;
    logic             usr;
  } entry_t;

  // window word offsets (byte offset / 4)
  localparam logic [2:0] OffTag    = 3'd0;
  localparam logic [2:0] OffData   = 3'd1;
  localparam logic [2:0] OffCmd    = 3'd2;
  localparam logic [2:0] OffPrAddr = 3'd3;
  localparam logic [2:0] OffPrRes  = 3'd4;
  localparam logic [2:0] OffFAddr  = 3'd5;
  localparam logic [2:0] OffFCause = 3'd6;
  localparam logic [2:0] OffStat   = 3'd7;

  // page-number bits that take part in the compare
  function automatic logic [PageW-1:0] sizeMask(input logic [1:0] size);
    case (size)
      2'd0:    sizeMask = 20'hFFFFF;
      2'd1:    sizeMask = 20'hFFFF0;
      default: sizeMask = 20'hFFF00;
    endcase
  endfunction
endpackage

// File: rtl/tlb_xlat_dp.sv
module tlb_xlat_dp
  import tlb_xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cmd_t             cmd,
  input  entry_t           stageEntry,
  input  logic [31:0]      probeAddr,
  input  logic             lkValid,
  input  logic [31:0]      lkAddr,
  input  logic             lkWrite,
  input  logic             lkUser,
  output logic             lkHit,
  output logic [31:0]      lkPhys,
  output logic             accErr,
  output logic             probeHit,
  output logic [IdxW-1:0]  probeIdx,
  output logic [31:0]      faultAddr,
  output cause_e           faultCause
);
  entry_t                ent [TlbEntries];
  logic [TlbEntries-1:0] entValid;
  logic [TlbEntries-1:0] lkMatch, prMatch;
  logic [IdxW-1:0]       rrPtr, wIdx, lkIdx;
  entry_t                selEnt;
  logic [PageW-1:0]      selMask;
  logic                  wrViol, prViol;
  cause_e                curCause;

  for (genvar i = 0; i < TlbEntries; i++) begin : g_ent
    logic [PageW-1:0] cmpMask;
    assign cmpMask    = sizeMask(ent[i].size);
    assign lkMatch[i] = entValid[i] && (((ent[i].vpn ^ lkAddr[31:12]) & cmpMask) == '0);
    assign prMatch[i] = entValid[i] && (((ent[i].vpn ^ probeAddr[31:12]) & cmpMask) == '0);
  end

  // lowest index wins on multiple matches
  always_comb begin
    lkHit    = 1'b0;
    lkIdx    = '0;
    probeHit = 1'b0;
    probeIdx = '0;
    for (int k = TlbEntries - 1; k >= 0; k--) begin
      if (lkMatch[k]) begin
        lkHit = 1'b1;
        lkIdx = IdxW'(k);
      end
      if (prMatch[k]) begin
        probeHit = 1'b1;
        probeIdx = IdxW'(k);
      end
    end
  end

  assign selEnt  = ent[lkIdx];
  assign selMask = sizeMask(selEnt.size);
  assign lkPhys  = {(selEnt.ppn & selMask) | (lkAddr[31:12] & ~selMask), lkAddr[11:0]};
  assign wrViol  = lkWrite && !selEnt.wr;
  assign prViol  = lkUser && !selEnt.usr;

  always_comb begin
    if (!lkHit)      curCause = CauseMiss;
    else if (prViol) curCause = CausePriv;
    else if (wrViol) curCause = CauseWrProt;
    else             curCause = CauseNone;
  end

  assign accErr = lkValid && (curCause != CauseNone);
  assign wIdx   = cmd.useIdx ? cmd.idx : rrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid   <= '0;
      rrPtr      <= '0;
      faultAddr  <= '0;
      faultCause <= CauseNone;
      for (int k = 0; k < TlbEntries; k++) ent[k] <= '0;
    end else begin
      if (cmd.clrAll) begin
        entValid <= '0;
      end else if (cmd.wrEntry) begin
        ent[wIdx]      <= stageEntry;
        entValid[wIdx] <= 1'b1;
        if (!cmd.useIdx)
          rrPtr <= (rrPtr == IdxW'(TlbEntries - 1)) ? '0 : rrPtr + IdxW'(1);
      end
      if (accErr) begin
        faultAddr  <= lkAddr;
        faultCause <= curCause;
      end
    end
  end
endmodule

// File: rtl/tlb_xlat_ctrl.sv
module tlb_xlat_ctrl
  import tlb_xlat_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            baseWe,
  input  logic [31:0]     baseWdata,
  output logic [31:0]     baseRdata,
  input  logic            busValid,
  input  logic            busWrite,
  input  logic [31:0]     busAddr,
  input  logic [31:0]     busWdata,
  output logic [31:0]     busRdata,
  input  logic            probeHit,
  input  logic [IdxW-1:0] probeIdx,
  input  logic [31:0]     faultAddr,
  input  cause_e          faultCause,
  output cmd_t            cmd,
  output entry_t          stageEntry,
  output logic [31:0]     probeAddr
);
  logic [15:0]     baseAddrQ;
  logic            baseVldQ;
  logic            prHitQ;
  logic [IdxW-1:0] prIdxQ;
  logic            misalignQ;
  logic            winSel, aligned, regSel, wrEn;
  logic [2:0]      off;

  assign winSel = busValid && baseVldQ && (busAddr[31:16] == baseAddrQ);
  assign aligned = (busAddr[1:0] == 2'b00);
  assign regSel = winSel && aligned && (busAddr[15:5] == '0);
  assign off    = busAddr[4:2];
  assign wrEn   = regSel && busWrite;

  assign baseRdata = {baseAddrQ, 15'd0, baseVldQ};

  always_comb begin
    cmd = '0;
    if (wrEn && off == OffCmd) begin
      cmd.wrEntry = busWdata[0];
      cmd.clrAll  = busWdata[1];
      cmd.probe   = busWdata[2];
      cmd.useIdx  = busWdata[3];
      cmd.idx     = busWdata[4 +: IdxW];
    end
  end

  always_comb begin
    busRdata = '0;
    if (regSel && !busWrite) begin
      case (off)
        OffTag:    busRdata = {stageEntry.vpn, 10'd0, stageEntry.size};
        OffData:   busRdata = {stageEntry.ppn, 10'd0, stageEntry.usr, stageEntry.wr};
        OffPrAddr: busRdata = probeAddr;
        OffPrRes:  busRdata = {prHitQ, {(31 - IdxW){1'b0}}, prIdxQ};
        OffFAddr:  busRdata = faultAddr;
        OffFCause: busRdata = {30'd0, faultCause};
        OffStat:   busRdata = {31'd0, misalignQ};
        default:   busRdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddrQ  <= '0;
      baseVldQ   <= 1'b0;
      stageEntry <= '0;
      probeAddr  <= '0;
      prHitQ     <= 1'b0;
      prIdxQ     <= '0;
      misalignQ  <= 1'b0;
    end else begin
      if (baseWe) begin
        baseAddrQ <= baseWdata[31:16];
        baseVldQ  <= baseWdata[0];
      end
      if (winSel && !aligned) misalignQ <= 1'b1;
      else if (wrEn && off == OffStat) misalignQ <= 1'b0;
      if (wrEn && off == OffTag) begin
        stageEntry.vpn  <= busWdata[31:12];
        stageEntry.size <= busWdata[1:0];
      end
      if (wrEn && off == OffData) begin
        stageEntry.ppn <= busWdata[31:12];
        stageEntry.usr <= busWdata[1];
        stageEntry.wr  <= busWdata[0];
      end
      if (wrEn && off == OffPrAddr) probeAddr <= busWdata;
      if (cmd.probe) begin
        prHitQ <= probeHit;
        prIdxQ <= probeIdx;
      end
    end
  end
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import tlb_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        baseWe,
  input  logic [31:0] baseWdata,
  output logic [31:0] baseRdata,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        lkValid,
  input  logic [31:0] lkAddr,
  input  logic        lkWrite,
  input  logic        lkUser,
  output logic        lkHit,
  output logic [31:0] lkPhys,
  output logic        accErr
);
  cmd_t            cmd;
  entry_t          stageEntry;
  logic [31:0]     probeAddr;
  logic            probeHit;
  logic [IdxW-1:0] probeIdx;
  logic [31:0]     faultAddr;
  cause_e          faultCause;

  tlb_xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .baseWe(baseWe), .baseWdata(baseWdata), .baseRdata(baseRdata),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .probeHit(probeHit), .probeIdx(probeIdx),
    .faultAddr(faultAddr), .faultCause(faultCause),
    .cmd(cmd), .stageEntry(stageEntry), .probeAddr(probeAddr)
  );

  tlb_xlat_dp u_dp (
    .clk(clk), .rstN(rstN),
    .cmd(cmd), .stageEntry(stageEntry), .probeAddr(probeAddr),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkWrite(lkWrite), .lkUser(lkUser),
    .lkHit(lkHit), .lkPhys(lkPhys), .accErr(accErr),
    .probeHit(probeHit), .probeIdx(probeIdx),
    .faultAddr(faultAddr), .faultCause(faultCause)
  );
endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk
  import tlb_xlat_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        lkValid,
  input logic        lkHit,
  input logic [31:0] lkAddr,
  input logic        accErr,
  input logic [31:0] faultAddr,
  input cause_e      faultCause,
  input logic [31:0] baseRdata,
  input logic [31:0] busRdata,
  input cmd_t        cmd
);
  p_miss_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkHit) |=> (faultCause == CauseMiss));

  p_fault_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    accErr |=> (faultAddr == $past(lkAddr)));

  p_fault_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !accErr |=> ($stable(faultAddr) && $stable(faultCause)));

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrAll |=> !lkHit);

  p_window_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !baseRdata[0] |-> (busRdata == '0));
endmodule

bind tlb_xlat tlb_xlat_chk u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkHit(lkHit), .lkAddr(lkAddr),
  .accErr(accErr), .faultAddr(faultAddr), .faultCause(faultCause),
  .baseRdata(baseRdata), .busRdata(busRdata), .cmd(cmd)
);

// File: tb/tlb_xlat_tb.sv
module tlb_xlat_tb;
  localparam int ClkPeriod = 10;
  localparam int N = 8;
  localparam logic [31:0] Win = 32'hA5C0_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic baseWe = 0; logic [31:0] baseWdata = '0; logic [31:0] baseRdata;
  logic busValid = 0, busWrite = 0; logic [31:0] busAddr = '0, busWdata = '0; logic [31:0] busRdata;
  logic lkValid = 0, lkWrite = 0, lkUser = 0; logic [31:0] lkAddr = '0;
  logic lkHit, accErr; logic [31:0] lkPhys;

  int nChecks = 0, nFails = 0;
  logic [19:0] mVpn [N]; logic [1:0] mSize [N]; logic [19:0] mPpn [N];
  logic mW [N], mU [N], mV [N];
  int mRr = 0; logic [31:0] mFA = '0; logic [1:0] mFC = '0;
  logic [31:0] rd;

  always #(ClkPeriod/2) clk = ~clk;

  tlb_xlat u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mMask(input logic [1:0] s);
    return (s == 0) ? 20'hFFFFF : (s == 1) ? 20'hFFFF0 : 20'hFFF00;
  endfunction

  function automatic int mFind(input logic [31:0] a);
    for (int i = 0; i < N; i++)
      if (mV[i] && (((mVpn[i] ^ a[31:12]) & mMask(mSize[i])) == 0)) return i;
    return -1;
  endfunction

  task automatic busWr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1 busValid = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1 busValid = 0;
  endtask

  task automatic setBase(input logic [31:0] v);
    @(negedge clk); baseWe = 1; baseWdata = v;
    @(posedge clk); #1 baseWe = 0;
  endtask

  task automatic writeEntry(input logic [19:0] vpn, input logic [1:0] sz, input logic [19:0] ppn,
                            input logic w, input logic u, input logic useIdx, input int idx);
    int t;
    busWr(Win + 32'h0, {vpn, 10'd0, sz});
    busWr(Win + 32'h4, {ppn, 10'd0, u, w});
    busWr(Win + 32'h8, {25'd0, idx[2:0], useIdx, 3'b001});
    t = useIdx ? idx : mRr;
    if (!useIdx) mRr = (mRr + 1) % N;
    mVpn[t] = vpn; mSize[t] = sz; mPpn[t] = ppn; mW[t] = w; mU[t] = u; mV[t] = 1;
  endtask

  task automatic clearAll(input logic alsoWrite);
    busWr(Win + 32'h8, {30'd0, 1'b1, alsoWrite});
    for (int i = 0; i < N; i++) mV[i] = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic w, input logic u, input string tag);
    int idx; logic [1:0] c; logic [19:0] m; logic [31:0] ep;
    idx = mFind(a);
    if (idx < 0) c = 1;
    else if (u && !mU[idx]) c = 3;
    else if (w && !mW[idx]) c = 2;
    else c = 0;
    @(negedge clk); lkValid = 1; lkAddr = a; lkWrite = w; lkUser = u;
    #1;
    chk({tag, " hit"}, {31'd0, lkHit}, {31'd0, idx >= 0});
    chk({tag, " err"}, {31'd0, accErr}, {31'd0, c != 0});
    if (c == 0) begin
      m = mMask(mSize[idx]);
      ep = {(mPpn[idx] & m) | (a[31:12] & ~m), a[11:0]};
      chk({tag, " phys"}, lkPhys, ep);
    end
    @(posedge clk); #1 lkValid = 0;
    if (c != 0) begin mFA = a; mFC = c; end
    busRd(Win + 32'h14, rd); chk("R5 fault address", rd, mFA);
    busRd(Win + 32'h18, rd); chk("R5 fault cause", rd, {30'd0, mFC});
  endtask

  task automatic probe(input logic [31:0] a, input string tag);
    int idx;
    idx = mFind(a);
    busWr(Win + 32'hC, a);
    busWr(Win + 32'h8, 32'h4);
    busRd(Win + 32'h10, rd);
    chk(tag, rd, (idx >= 0) ? (32'h8000_0000 | idx) : 32'h0);
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete");
    finishTest();
  end

  initial begin
    logic [11:0] pfx [4];
    int seedDummy;
    pfx[0] = 12'h123; pfx[1] = 12'h456; pfx[2] = 12'h789; pfx[3] = 12'hABC;
    seedDummy = $urandom(32'd4242);
    for (int i = 0; i < N; i++) mV[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R8 / R9 reset state
    #1 chk("R8 base reset", baseRdata, 32'h0);
    busRd(Win + 32'h10, rd); chk("R9 window closed at reset", rd, 32'h0);

    setBase(32'hA5C0_FFFF);
    #1 chk("R8 reserved bits read zero", baseRdata, 32'hA5C0_0001);
    busRd(Win + 32'h18, rd); chk("R5 cause reset", rd, 32'h0);

    // R9 base mismatch
    busWr(32'h1234_000C, 32'hDEAD_BEEF);
    busRd(32'h1234_000C, rd); chk("R9 mismatch read", rd, 32'h0);
    busRd(Win + 32'hC, rd); chk("R9 mismatch write ignored", rd, 32'h0);

    // R10 misaligned
    busWr(Win + 32'h1, 32'hFFFF_F003);
    busRd(Win + 32'h0, rd); chk("R10 misaligned write ignored", rd, 32'h0);
    busRd(Win + 32'h1C, rd); chk("R10 flag set", rd, 32'h1);
    busWr(Win + 32'h1C, 32'h0);
    busRd(Win + 32'h1C, rd); chk("R10 flag cleared", rd, 32'h0);

    // R3 miss on empty buffer
    lookup(32'hDEAD_0123, 0, 0, "R3 empty miss");

    // R1 / R2 page sizes, R11 round robin to 0,1,2
    writeEntry(20'h12345, 2'd0, 20'hABCDE, 1, 1, 0, 0);
    writeEntry(20'h40000, 2'd1, 20'h77770, 1, 1, 0, 0);
    writeEntry(20'h80000, 2'd2, 20'h30000, 0, 0, 0, 0);
    lookup(32'h1234_5678, 1, 1, "R1 4KB hit");
    lookup(32'h1234_6678, 0, 0, "R2 4KB neighbour miss");
    lookup(32'h4000_ABCD, 0, 1, "R2 64KB hit");
    lookup(32'h8001_2345, 0, 0, "R2 1MB hit");
    lookup(32'h8001_2345, 1, 0, "R4 write protect");
    lookup(32'h8001_2345, 0, 1, "R4 privilege");
    lookup(32'h800F_FFFC, 1, 1, "R4 both, privilege wins");
    lookup(32'h1234_5000, 0, 0, "R5 hit keeps fault regs");

    // R11 explicit index then round robin
    writeEntry(20'h55555, 2'd0, 20'h11111, 1, 1, 1, 6);
    probe(32'h5555_5000, "R11 explicit index 6");
    writeEntry(20'h66666, 2'd0, 20'h22222, 1, 1, 0, 0);
    probe(32'h6666_6000, "R11 round robin index 3");

    // R12 / R7 overlap, lowest index wins
    writeEntry(20'h90000, 2'd2, 20'h44400, 0, 1, 1, 5);
    writeEntry(20'h90012, 2'd0, 20'h55512, 1, 1, 1, 4);
    lookup(32'h9001_2ABC, 1, 0, "R12 lowest index");
    probe(32'h9001_2ABC, "R7 probe lowest index");
    probe(32'hF000_0000, "R7 probe miss");
    busRd(Win + 32'h14, rd); chk("R7 probe leaves fault address", rd, mFA);

    // R6 clear all together with write
    clearAll(1'b1);
    lookup(32'h1234_5678, 0, 0, "R6 cleared");
    probe(32'h4000_0000, "R6 probe after clear");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int op; logic [31:0] a;
      op = $urandom_range(0, 9);
      a = {pfx[$urandom_range(0, 3)], 8'($urandom), 12'($urandom)};
      if (op <= 2) begin
        logic ui; ui = ($urandom_range(0, 2) == 0);
        writeEntry({pfx[$urandom_range(0, 3)], 8'($urandom)}, 2'($urandom), 20'($urandom),
                   1'($urandom), 1'($urandom), ui, $urandom_range(0, N - 1));
      end else if (op == 8) probe(a, "R7 random probe");
      else if (op == 9 && $urandom_range(0, 3) == 0) clearAll(1'b0);
      else lookup(a, 1'($urandom), 1'($urandom), "R1 R2 R4 R12 random lookup");
    end

    // R9 disable window again
    setBase(32'hA5C0_0000);
    busRd(Win + 32'h14, rd); chk("R9 window disabled", rd, 32'h0);

    finishTest();
  end
endmodule